// File: doc/BRIEF.md
# Interrupt Message Queue and Handler Dispatch Sequencer

This block sits beside the instruction pipeline of a small 16-bit processor and controls entry into interrupt handlers and the return from them. It keeps a first-in, first-out store of pending 16-bit messages. Messages come from two sources: a software raise strobe, which carries the operand of the raising instruction, and a hardware request strobe from peripherals. At each instruction boundary the core pulses `slot_req`. If queueing is off, the block then takes the oldest pending message. It saves the current program counter and accumulator register on a descending memory stack, jumps to the handler vector, and places the message in the accumulator.

The core forwards decoded commands on a small command bus. The commands are: load the handler vector, turn queueing on or off, return from a handler, and halt. The block reports the handler vector, the queueing flag, the halted flag and a sticky overflow fault. All stack traffic goes through a single-word memory port. Reads on that port return data one cycle after the read strobe, as a synchronous RAM does. Writes to the core's program counter and accumulator leave the block as single-cycle write strobes with data.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: After reset, the handler vector is 0, queueing is off, halted is 0, the overflow fault is 0 and busy is 0. The stack pointer starts at 0xFFFF, so the first push writes address 0xFFFE.
- R2: A software raise is dropped without effect while the handler vector is 0. A later dispatch attempt then finds nothing.
- R3: Messages leave in arrival order. If software and hardware strobes fire in the same cycle, the software message is stored first.
- R4: A dispatch is taken only on `slot_req`, while idle, with queueing off and a message pending. A command in the same cycle wins, and that `slot_req` is dropped.
- R5: A dispatch first writes the saved PC at SP-1, then writes the saved accumulator at SP-2 on the next cycle. In the third cycle it strobes `pc_we` with the handler vector and `a_we` with the message, and it turns queueing on.
- R6: A dispatch with a handler vector of 0 removes the oldest message and throws it away. It makes no memory, PC or accumulator write.
- R7: Return (cmd_op 2) turns queueing off. It reads SP and then SP+1 on consecutive cycles. The first word goes to the accumulator and the second goes to the PC, each written two cycles after its read strobe. The memory port never reads and writes in the same cycle.
- R8: The queue command (cmd_op 1) turns queueing on for a nonzero argument and off for a zero argument.
- R9: The set-vector command (cmd_op 0) loads `cmd_arg` into the handler vector, which appears on `ia_value` on the next cycle.
- R10: A hardware strobe stores its message even when the handler vector is 0, and it clears halted. The halt command (cmd_op 3) sets halted. A hardware strobe in the same cycle as halt wins.
- R11: The store holds 256 messages. A software raise with a nonzero vector while 256 are pending stores nothing and sets `on_fire`, which stays set until reset. A hardware strobe that finds no room is dropped.
- R12: `busy` rises on the edge that accepts a dispatch or a return. It falls on the edge of the final PC write, three cycles into a dispatch and four into a return. `pc_we` never coincides with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req | input | 1 | Software raise strobe |
| sw_msg | input | 16 | Software raise message |
| hw_req | input | 1 | Hardware request strobe |
| hw_msg | input | 16 | Hardware request message |
| slot_req | input | 1 | Instruction boundary, dispatch attempt |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 set vector, 1 queue, 2 return, 3 halt |
| cmd_arg | input | 16 | Command argument |
| cur_pc | input | 16 | Current program counter of the core |
| cur_a | input | 16 | Current accumulator of the core |
| busy | output | 1 | Dispatch or return sequence in progress |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | 16 | PC write value |
| a_we | output | 1 | Accumulator write strobe |
| a_wdata | output | 16 | Accumulator write value |
| mem_we | output | 1 | Stack memory write |
| mem_re | output | 1 | Stack memory read |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 16 | Stack memory write data |
| mem_rdata | input | 16 | Stack memory read data, one cycle after read |
| ia_value | output | 16 | Handler vector |
| queue_on | output | 1 | Queueing flag |
| halted | output | 1 | Halted flag |
| on_fire | output | 1 | Sticky overflow fault |

## Verification
Dispatch and return are each run as a pair over a table of vector, message, PC and accumulator values. The table includes all-zero and all-one words and alternating bit patterns, so that swapped stack slots or swapped PC and accumulator data show up as mismatches. Alternate rows enter through the software and the hardware strobe, which separates the two enqueue paths. A dual-strobe cycle tells stored order from strobe priority. Runs with a zero vector tell dropping at entry (software) from storing with a later discard (hardware). A full fill followed by a drain tells exact capacity, the sticky fault and the dropping of late hardware requests from an off-by-one in the occupancy count.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  typedef enum logic [1:0] {
    CMD_SET_VEC = 2'd0,
    CMD_QUEUE   = 2'd1,
    CMD_RETURN  = 2'd2,
    CMD_HALT    = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_A,
    ST_LOAD,
    ST_POP_PC,
    ST_TAKE_A,
    ST_TAKE_PC
  } seq_e;
endpackage

// File: rtl/isq_fifo.sv
module isq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push0,
  input  logic [W-1:0] d0,
  input  logic         push1,
  input  logic [W-1:0] d1,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          acc0, acc1;

  // port 0 has priority for the last free slot
  assign acc0 = push0 && (count < CW'(DEPTH));
  assign acc1 = push1 && ((count + CW'(acc0)) < CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (acc0) store[wr_ptr] <= d0;
    if (acc1) store[wr_ptr + AW'(acc0)] <= d1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(acc0) + AW'(acc1);
      rd_ptr <= rd_ptr + AW'(pop);
      count  <= count + CW'(acc0) + CW'(acc1) - CW'(pop);
    end
  end

  assign head  = store[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/isq_regs.sv
module isq_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_vec,
  input  logic         queue_cmd,
  input  logic         halt_cmd,
  input  logic [W-1:0] arg,
  input  logic         qen_set,
  input  logic         qen_clr,
  input  logic         wake,
  input  logic         fire_evt,
  output logic [W-1:0] vec,
  output logic         qen,
  output logic         halted,
  output logic         fire
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vec    <= '0;
      qen    <= 1'b0;
      halted <= 1'b0;
      fire   <= 1'b0;
    end else begin
      if (set_vec) vec <= arg;
      if (qen_clr)        qen <= 1'b0;
      else if (qen_set)   qen <= 1'b1;
      else if (queue_cmd) qen <= (arg != '0);
      if (wake)           halted <= 1'b0;
      else if (halt_cmd)  halted <= 1'b1;
      if (fire_evt) fire <= 1'b1;
    end
  end
endmodule

// File: rtl/isq_seq.sv
module isq_seq
  import irq_dispatch_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         slot_req,
  input  logic         cmd_valid,
  input  cmd_e         cmd_op,
  input  logic [W-1:0] vec,
  input  logic         qen,
  input  logic         fifo_empty,
  input  logic [W-1:0] fifo_head,
  input  logic [W-1:0] cur_pc,
  input  logic [W-1:0] cur_a,
  input  logic [W-1:0] mem_rdata,
  output logic         fifo_pop,
  output logic         qen_set,
  output logic         qen_clr,
  output logic         set_vec,
  output logic         queue_cmd,
  output logic         halt_cmd,
  output logic         busy,
  output logic         pc_we,
  output logic [W-1:0] pc_wdata,
  output logic         a_we,
  output logic [W-1:0] a_wdata,
  output logic         mem_we,
  output logic         mem_re,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata
);
  seq_e         state;
  logic [W-1:0] sp, msg_q, a_snap;
  logic         idle, cmd_go, ret_go, take, launch;

  assign idle      = (state == ST_IDLE);
  assign cmd_go    = idle && cmd_valid;
  assign set_vec   = cmd_go && (cmd_op == CMD_SET_VEC);
  assign queue_cmd = cmd_go && (cmd_op == CMD_QUEUE);
  assign halt_cmd  = cmd_go && (cmd_op == CMD_HALT);
  assign ret_go    = cmd_go && (cmd_op == CMD_RETURN);
  assign take      = idle && !cmd_valid && slot_req && !qen && !fifo_empty;
  assign launch    = take && (vec != '0);
  assign fifo_pop  = take;
  assign qen_clr   = ret_go;
  assign qen_set   = (state == ST_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sp        <= {W{1'b1}};
      msg_q     <= '0;
      a_snap    <= '0;
      busy      <= 1'b0;
      pc_we     <= 1'b0;
      pc_wdata  <= '0;
      a_we      <= 1'b0;
      a_wdata   <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      pc_we  <= 1'b0;
      a_we   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (launch) begin
            msg_q     <= fifo_head;
            a_snap    <= cur_a;
            mem_we    <= 1'b1;
            mem_addr  <= sp - W'(1);
            mem_wdata <= cur_pc;
            sp        <= sp - W'(1);
            busy      <= 1'b1;
            state     <= ST_PUSH_A;
          end else if (ret_go) begin
            mem_re   <= 1'b1;
            mem_addr <= sp;
            sp       <= sp + W'(1);
            busy     <= 1'b1;
            state    <= ST_POP_PC;
          end
        end
        ST_PUSH_A: begin
          mem_we    <= 1'b1;
          mem_addr  <= sp - W'(1);
          mem_wdata <= a_snap;
          sp        <= sp - W'(1);
          state     <= ST_LOAD;
        end
        ST_LOAD: begin
          pc_we    <= 1'b1;
          pc_wdata <= vec;
          a_we     <= 1'b1;
          a_wdata  <= msg_q;
          busy     <= 1'b0;
          state    <= ST_IDLE;
        end
        ST_POP_PC: begin
          mem_re   <= 1'b1;
          mem_addr <= sp;
          sp       <= sp + W'(1);
          state    <= ST_TAKE_A;
        end
        ST_TAKE_A: begin
          a_we    <= 1'b1;
          a_wdata <= mem_rdata;
          state   <= ST_TAKE_PC;
        end
        ST_TAKE_PC: begin
          pc_we    <= 1'b1;
          pc_wdata <= mem_rdata;
          busy     <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
  import irq_dispatch_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sw_req,
  input  logic [W-1:0] sw_msg,
  input  logic         hw_req,
  input  logic [W-1:0] hw_msg,
  input  logic         slot_req,
  input  logic         cmd_valid,
  input  logic [1:0]   cmd_op,
  input  logic [W-1:0] cmd_arg,
  input  logic [W-1:0] cur_pc,
  input  logic [W-1:0] cur_a,
  output logic         busy,
  output logic         pc_we,
  output logic [W-1:0] pc_wdata,
  output logic         a_we,
  output logic [W-1:0] a_wdata,
  output logic         mem_we,
  output logic         mem_re,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] ia_value,
  output logic         queue_on,
  output logic         halted,
  output logic         on_fire
);
  logic         sw_live, fifo_pop, fifo_empty, fifo_full;
  logic [W-1:0] fifo_head;
  logic         qen_set, qen_clr, set_vec, queue_cmd, halt_cmd;

  assign sw_live = sw_req && (ia_value != '0);

  isq_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push0(sw_live), .d0(sw_msg),
    .push1(hw_req),  .d1(hw_msg),
    .pop(fifo_pop), .head(fifo_head),
    .empty(fifo_empty), .full(fifo_full)
  );

  isq_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst),
    .set_vec(set_vec), .queue_cmd(queue_cmd), .halt_cmd(halt_cmd),
    .arg(cmd_arg), .qen_set(qen_set), .qen_clr(qen_clr),
    .wake(hw_req), .fire_evt(sw_live && fifo_full),
    .vec(ia_value), .qen(queue_on), .halted(halted), .fire(on_fire)
  );

  isq_seq #(.W(W)) u_seq (
    .clk(clk), .rst(rst),
    .slot_req(slot_req), .cmd_valid(cmd_valid), .cmd_op(cmd_e'(cmd_op)),
    .vec(ia_value), .qen(queue_on),
    .fifo_empty(fifo_empty), .fifo_head(fifo_head),
    .cur_pc(cur_pc), .cur_a(cur_a), .mem_rdata(mem_rdata),
    .fifo_pop(fifo_pop), .qen_set(qen_set), .qen_clr(qen_clr),
    .set_vec(set_vec), .queue_cmd(queue_cmd), .halt_cmd(halt_cmd),
    .busy(busy), .pc_we(pc_we), .pc_wdata(pc_wdata),
    .a_we(a_we), .a_wdata(a_wdata),
    .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/irq_dispatch_ctrl_chk.sv
module irq_dispatch_ctrl_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         hw_req,
  input logic         busy,
  input logic         pc_we,
  input logic [W-1:0] pc_wdata,
  input logic         a_we,
  input logic         mem_we,
  input logic         mem_re,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] ia_value,
  input logic         queue_on,
  input logic         halted,
  input logic         on_fire
);
  // R11
  fire_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    on_fire |=> on_fire);

  // R5
  push_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |=> (mem_we && ((mem_addr + W'(1)) == $past(mem_addr))));

  // R7
  pop_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_re) |=> (mem_re && (mem_addr == $past(mem_addr) + W'(1))));

  // R5
  handler_load_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_we && a_we) |-> ((pc_wdata == ia_value) && queue_on));

  // R10
  wake_chk: assert property (@(posedge clk) disable iff (rst)
    hw_req |=> !halted);

  // R7
  port_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  // R12
  final_write_chk: assert property (@(posedge clk) disable iff (rst)
    pc_we |-> !busy);
endmodule

bind irq_dispatch_ctrl irq_dispatch_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .hw_req(hw_req), .busy(busy),
  .pc_we(pc_we), .pc_wdata(pc_wdata), .a_we(a_we),
  .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
  .ia_value(ia_value), .queue_on(queue_on), .halted(halted),
  .on_fire(on_fire)
);

// File: tb/irq_dispatch_ctrl_tb.sv
`timescale 1ns/1ps
module irq_dispatch_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_req = 0, hw_req = 0, slot_req = 0, cmd_valid = 0;
  logic [15:0] sw_msg = 0, hw_msg = 0, cmd_arg = 0, cur_pc = 0, cur_a = 0;
  logic [1:0]  cmd_op = 0;
  logic        busy, pc_we, a_we, mem_we, mem_re, queue_on, halted, on_fire;
  logic [15:0] pc_wdata, a_wdata, mem_addr, mem_wdata, ia_value;
  logic [15:0] mem_rdata = 0;
  logic [15:0] bmem [256];
  logic [15:0] bsp = 16'hFFFF;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  irq_dispatch_ctrl u_dut (
    .clk(clk), .rst(rst), .sw_req(sw_req), .sw_msg(sw_msg),
    .hw_req(hw_req), .hw_msg(hw_msg), .slot_req(slot_req),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .cur_pc(cur_pc), .cur_a(cur_a), .busy(busy),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .a_we(a_we), .a_wdata(a_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ia_value(ia_value),
    .queue_on(queue_on), .halted(halted), .on_fire(on_fire)
  );

  always @(posedge clk) begin
    if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= bmem[mem_addr[7:0]];
  end

  // {message, handler vector, pc, accumulator}
  localparam logic [63:0] VEC [6] = '{
    {16'h0000, 16'h1000, 16'hFFFF, 16'hAAAA},
    {16'hFFFF, 16'h0001, 16'h0000, 16'h5555},
    {16'h1234, 16'hFFFF, 16'h8001, 16'h0000},
    {16'hA5A5, 16'h4000, 16'h5A5A, 16'hFFFF},
    {16'h0001, 16'h8000, 16'h0002, 16'h7FFF},
    {16'h8000, 16'h0F0F, 16'hF0F0, 16'h0100}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic send_cmd(logic [1:0] op, logic [15:0] arg);
    @(negedge clk); cmd_valid = 1; cmd_op = op; cmd_arg = arg;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic raise_sw(logic [15:0] m);
    @(negedge clk); sw_req = 1; sw_msg = m;
    @(negedge clk); sw_req = 0;
  endtask

  task automatic raise_hw(logic [15:0] m);
    @(negedge clk); hw_req = 1; hw_msg = m;
    @(negedge clk); hw_req = 0;
  endtask

  task automatic dispatch(string req, logic [15:0] msg, logic [15:0] vec,
                          logic [15:0] pc, logic [15:0] a);
    @(negedge clk); slot_req = 1; cur_pc = pc; cur_a = a;
    @(negedge clk); slot_req = 0;
    chk({req, " push pc we"}, mem_we, 1);
    chk({req, " push pc addr"}, mem_addr, 16'(bsp - 16'd1));
    chk({req, " push pc data"}, mem_wdata, pc);
    chk({req, " busy"}, busy, 1);
    @(negedge clk);
    chk({req, " push a we"}, mem_we, 1);
    chk({req, " push a addr"}, mem_addr, 16'(bsp - 16'd2));
    chk({req, " push a data"}, mem_wdata, a);
    @(negedge clk);
    chk({req, " pc we"}, pc_we, 1);
    chk({req, " pc data"}, pc_wdata, vec);
    chk({req, " a we"}, a_we, 1);
    chk({req, " a data"}, a_wdata, msg);
    chk({req, " queue on"}, queue_on, 1);
    chk({req, " busy done"}, busy, 0);
    bsp = 16'(bsp - 16'd2);
  endtask

  task automatic no_dispatch(string req);
    @(negedge clk); slot_req = 1;
    @(negedge clk); slot_req = 0;
    chk({req, " no write"}, mem_we, 0);
    chk({req, " not busy"}, busy, 0);
    @(negedge clk);
    chk({req, " no pc/a"}, {pc_we, a_we}, 0);
  endtask

  task automatic do_return(string req, logic [15:0] a, logic [15:0] pc);
    @(negedge clk); cmd_valid = 1; cmd_op = 2'd2;
    @(negedge clk); cmd_valid = 0;
    chk({req, " read1"}, {mem_re, mem_we}, 2'b10);
    chk({req, " read1 addr"}, mem_addr, bsp);
    chk({req, " queue off"}, queue_on, 0);
    chk({req, " busy"}, busy, 1);
    @(negedge clk);
    chk({req, " read2"}, mem_re, 1);
    chk({req, " read2 addr"}, mem_addr, 16'(bsp + 16'd1));
    @(negedge clk);
    chk({req, " a we"}, {a_we, pc_we}, 2'b10);
    chk({req, " a data"}, a_wdata, a);
    @(negedge clk);
    chk({req, " pc we"}, {pc_we, a_we}, 2'b10);
    chk({req, " pc data"}, pc_wdata, pc);
    chk({req, " busy done"}, busy, 0);
    bsp = 16'(bsp + 16'd2);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 vector", ia_value, 0);
    chk("R1 flags", {queue_on, halted, on_fire, busy}, 0);
    chk("R1 strobes", {pc_we, a_we, mem_we, mem_re}, 0);

    // table walk: R1 (first push at 0xFFFE), R5, R7, R9
    for (int i = 0; i < 6; i++) begin
      send_cmd(2'd0, VEC[i][47:32]);
      chk("R9 vector load", ia_value, VEC[i][47:32]);
      if (i % 2 == 0) raise_sw(VEC[i][63:48]);
      else            raise_hw(VEC[i][63:48]);
      dispatch("R1 R5 table", VEC[i][63:48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0]);
      do_return("R7 table", VEC[i][15:0], VEC[i][31:16]);
    end

    // R2: software raise dropped with zero vector
    send_cmd(2'd0, 16'h0000);
    raise_sw(16'h0066);
    send_cmd(2'd0, 16'h0400);
    no_dispatch("R2 dropped");

    // R6: stored hardware message discarded at dispatch with zero vector
    send_cmd(2'd0, 16'h0000);
    raise_hw(16'h0055);
    no_dispatch("R6 discard");
    send_cmd(2'd0, 16'h0400);
    no_dispatch("R6 queue empty");

    // R3: same-cycle strobes, software first
    @(negedge clk); sw_req = 1; sw_msg = 16'h0011; hw_req = 1; hw_msg = 16'h0022;
    @(negedge clk); sw_req = 0; hw_req = 0;
    dispatch("R3 first", 16'h0011, 16'h0400, 16'h0010, 16'h0020);
    do_return("R3 ret1", 16'h0020, 16'h0010);
    dispatch("R3 second", 16'h0022, 16'h0400, 16'h0030, 16'h0040);
    do_return("R3 ret2", 16'h0040, 16'h0030);

    // R4: command wins over slot_req
    send_cmd(2'd0, 16'h0500);
    raise_sw(16'h0088);
    @(negedge clk); slot_req = 1; cmd_valid = 1; cmd_op = 2'd0; cmd_arg = 16'h0600;
    @(negedge clk); slot_req = 0; cmd_valid = 0;
    chk("R4 cmd priority no write", mem_we, 0);
    chk("R4 R9 vector", ia_value, 16'h0600);
    dispatch("R4 after cmd", 16'h0088, 16'h0600, 16'h0111, 16'h0222);
    // R4: queueing on after dispatch blocks the next one
    raise_sw(16'h0099);
    no_dispatch("R4 handler blocks");
    do_return("R4 ret", 16'h0222, 16'h0111);
    dispatch("R4 resumes", 16'h0099, 16'h0600, 16'h0333, 16'h0444);
    do_return("R4 ret2", 16'h0444, 16'h0333);

    // R8: queue command
    send_cmd(2'd1, 16'h0100);
    chk("R8 queue on", queue_on, 1);
    raise_hw(16'h00AB);
    no_dispatch("R8 queued");
    send_cmd(2'd1, 16'h0000);
    chk("R8 queue off", queue_on, 0);
    dispatch("R8 released", 16'h00AB, 16'h0600, 16'h0555, 16'h0666);
    do_return("R8 ret", 16'h0666, 16'h0555);

    // R10: halt and wake; hardware stored with zero vector
    send_cmd(2'd0, 16'h0000);
    send_cmd(2'd3, 16'h0000);
    chk("R10 halted", halted, 1);
    raise_hw(16'h0077);
    chk("R10 woken", halted, 0);
    @(negedge clk); cmd_valid = 1; cmd_op = 2'd3; hw_req = 1; hw_msg = 16'h0078;
    @(negedge clk); cmd_valid = 0; hw_req = 0;
    chk("R10 wake wins", halted, 0);
    send_cmd(2'd0, 16'h0300);
    dispatch("R10 kept", 16'h0077, 16'h0300, 16'h0700, 16'h0800);
    do_return("R10 ret", 16'h0800, 16'h0700);
    dispatch("R10 kept2", 16'h0078, 16'h0300, 16'h0701, 16'h0801);
    do_return("R10 ret2", 16'h0801, 16'h0701);

    // R11: capacity, sticky fault, hardware dropped when full
    send_cmd(2'd0, 16'h0700);
    for (int i = 0; i < 256; i++) raise_sw(16'(i) ^ 16'h5A00);
    chk("R11 no fault at 256", on_fire, 0);
    raise_sw(16'hDEAD);
    chk("R11 fault", on_fire, 1);
    raise_hw(16'hBEEF);
    for (int i = 0; i < 256; i++) begin
      dispatch("R11 drain", 16'(i) ^ 16'h5A00, 16'h0700, 16'(i), 16'(~i));
      do_return("R11 drain ret", 16'(~i), 16'(i));
    end
    no_dispatch("R11 overflow dropped");
    chk("R11 sticky", on_fire, 1);

    summary();
    $finish;
  end
endmodule